// File: doc/BRIEF.md
# Precise Trap Controller

This block decides when an in-order pipeline leaves normal execution for a trap handler and when it comes back. Each cycle it looks at a set of instruction slots, from the youngest (index 0) to the oldest, the write-back slot (index `NSTG-1`). Each slot has a valid flag, an exception flag and a program counter. The block also sees a level-sensitive external interrupt request and a return-from-trap marker on the write-back slot.

A synchronous fault takes effect only when the faulting instruction reaches write-back. Because that slot is the oldest in flight, the earliest fault in program order always wins. An external request is not tied to any instruction. It is accepted at the oldest valid instruction that carries no fault, and is deferred while that instruction is faulting or while the pipeline is empty.

When a trap is taken, the block squashes every slot, including the write-back instruction, so nothing at or after the trap point commits. It records the restart PC, the cause code and the previous privilege level in shadow registers. It redirects fetch to a fixed handler address. The privilege level rises at the clock edge that ends the squash cycle, so no instruction that was in flight ever runs with the raised level. A return-from-trap in privileged mode commits, squashes the younger slots, jumps to the saved PC, restores the saved privilege level and re-enables external requests. General-purpose registers are left to the handler.

Top module: `precise_trap_ctrl`

## Requirements
- R1: After reset, `mode_o` is 1 (privileged), `irq_masked_o` is 0, `epc_o`, `cause_o` and `saved_mode_o` are 0, and no flush is signalled while the inputs are idle.
- R2: When no event is taken, `flush_o` is 0 and `wb_commit_o` equals the valid flag of slot `NSTG-1`.
- R3: A valid write-back slot with its exception flag set raises `flush_o`, lowers `wb_commit_o` and drives `redirect_pc_o` to `HANDLER_PC` in that cycle. In the following cycle `epc_o` holds that slot's PC, `cause_o` holds `wb_cause_i`, `saved_mode_o` holds the previous `mode_o`, `mode_o` is 1 and `irq_masked_o` is 1.
- R4: With `irq_i` high and requests unmasked, the interrupt is taken at the highest-index valid slot if its exception flag is clear. The flush, redirect and state updates are those of R3, except that `epc_o` becomes that slot's PC and `cause_o` becomes all ones (15 with a 4-bit cause).
- R5: An external request is deferred (no flush) when no slot is valid or when the highest-index valid slot has its exception flag set.
- R6: When a write-back fault and an external request arrive in the same cycle, the fault is taken with its own cause code.
- R7: While `irq_masked_o` is 1, `irq_i` has no effect: there is no flush, and a valid write-back instruction commits.
- R8: A valid, non-faulting return-from-trap at write-back in privileged mode commits, raises `flush_o` and drives `redirect_pc_o` to `epc_o`. In the following cycle `mode_o` equals the former `saved_mode_o` and `irq_masked_o` is 0.
- R9: A return-from-trap at write-back in user mode (`mode_o` 0) is a fault with cause all ones minus one (14 with a 4-bit cause), saving its own PC as the restart point.
- R10: `mode_o` keeps its old value during the cycle in which `flush_o` is high and changes only at the edge that ends that cycle.
- R11: A slot other than write-back with its exception flag set causes no flush by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid_i | input | NSTG | Valid flag per slot, bit NSTG-1 is write-back |
| slot_exc_i | input | NSTG | Synchronous exception flag per slot |
| slot_pc_i | input | NSTG*PCW | PC per slot, slot s at bits [s*PCW +: PCW] |
| wb_cause_i | input | CW | Fault cause of the write-back instruction |
| wb_rfi_i | input | 1 | Write-back instruction is a return-from-trap |
| irq_i | input | 1 | Level-sensitive external interrupt request |
| wb_commit_o | output | 1 | Write-back instruction may update architectural state |
| flush_o | output | 1 | Squash all slots and fetch from redirect_pc_o |
| redirect_pc_o | output | PCW | Fetch target while flush_o is high |
| mode_o | output | 1 | Current privilege level, 1 = privileged |
| epc_o | output | PCW | Saved restart PC |
| cause_o | output | CW | Saved cause code |
| saved_mode_o | output | 1 | Privilege level held before the last trap |
| irq_masked_o | output | 1 | External requests are blocked |

## Verification
The assertions assume the pipeline honours a flush: slot contents may change freely from one cycle to the next, but `slot_valid_i` reflects only instructions that are actually in flight. They also assume the external request is sampled only at clock edges and is not glitched within a cycle. The stimulus drives every input at the falling edge, so each combination is presented whole for a full cycle. A sweep steps through all combinations of valid and exception patterns with every setting of request and return marker, and the state carries over from step to step, so privileged and user modes and masked and unmasked phases all occur naturally.

// File: rtl/ptc_pkg.sv
// Shared types for the precise trap controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ptc_pkg;

    // Event chosen in a cycle, at most one.
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_FAULT   = 3'd1,
        EV_ILLEGAL = 3'd2,
        EV_RETURN  = 3'd3,
        EV_IRQ     = 3'd4
    } ptc_event_e;

endpackage

// File: rtl/ptc_point_pick.sv
// Finds the oldest valid slot (highest index) and reports its fault flag
// and PC. This is the candidate boundary for an external interrupt.
// Assumes slot NSTG-1 is the oldest and slot 0 the youngest.
module ptc_point_pick #(
    parameter int NSTG = 5,
    parameter int PCW  = 16
) (
    input  logic [NSTG-1:0]     slot_valid_i,
    input  logic [NSTG-1:0]     slot_exc_i,
    input  logic [NSTG*PCW-1:0] slot_pc_i,
    output logic                found_o,
    output logic                found_exc_o,
    output logic [PCW-1:0]      found_pc_o
);

    logic [PCW-1:0] pc_arr [NSTG];

    // Unpack the flat PC bus into one entry per slot.
    for (genvar s = 0; s < NSTG; s++) begin : g_unpack
        assign pc_arr[s] = slot_pc_i[s*PCW +: PCW];
    end

    // Scan young to old so that the oldest valid slot overwrites the rest.
    always_comb begin
        found_o     = 1'b0;
        found_exc_o = 1'b0;
        found_pc_o  = '0;
        for (int s = 0; s < NSTG; s++) begin
            if (slot_valid_i[s]) begin
                found_o     = 1'b1;
                found_exc_o = slot_exc_i[s];
                found_pc_o  = pc_arr[s];
            end
        end
    end

endmodule

// File: rtl/ptc_arbiter.sv
// Chooses the single event for this cycle. Priority: write-back fault,
// return-from-trap in user mode (illegal), return-from-trap in privileged
// mode, then an unmasked external request at a clean boundary.
// Assumes all inputs are settled within the cycle.
module ptc_arbiter
    import ptc_pkg::*;
(
    input  logic       wb_valid_i,
    input  logic       wb_exc_i,
    input  logic       wb_rfi_i,
    input  logic       mode_i,
    input  logic       mask_i,
    input  logic       irq_i,
    input  logic       point_found_i,
    input  logic       point_exc_i,
    output ptc_event_e ev_o
);

    logic irq_ok;

    // An external request needs an unmasked state and a fault-free oldest instruction.
    assign irq_ok = irq_i && !mask_i && point_found_i && !point_exc_i;

    // Fixed-priority choice of the event.
    always_comb begin
        if (wb_valid_i && wb_exc_i) begin
            ev_o = EV_FAULT;
        end else if (wb_valid_i && wb_rfi_i && !mode_i) begin
            ev_o = EV_ILLEGAL;
        end else if (wb_valid_i && wb_rfi_i) begin
            ev_o = EV_RETURN;
        end else if (irq_ok) begin
            ev_o = EV_IRQ;
        end else begin
            ev_o = EV_NONE;
        end
    end

endmodule

// File: rtl/ptc_shadow.sv
// Holds the privilege level, the external-request mask and the saved
// restart state. A trap saves the state and raises the level. A return
// restores the level and clears the mask.
// Assumes ev_i is one-per-cycle from the arbiter; synchronous active-low reset.
module ptc_shadow
    import ptc_pkg::*;
#(
    parameter int PCW = 16,
    parameter int CW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ptc_event_e     ev_i,
    input  logic [PCW-1:0] trap_pc_i,
    input  logic [CW-1:0]  trap_cause_i,
    output logic           mode_o,
    output logic           mask_o,
    output logic [PCW-1:0] epc_o,
    output logic [CW-1:0]  cause_o,
    output logic           saved_mode_o
);

    logic           mode_q;
    logic           mask_q;
    logic [PCW-1:0] epc_q;
    logic [CW-1:0]  cause_q;
    logic           smode_q;
    logic           is_trap;

    assign is_trap = (ev_i == EV_FAULT) || (ev_i == EV_ILLEGAL) || (ev_i == EV_IRQ);

    // Update the privilege level and saved state on trap or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b1;
            mask_q  <= 1'b0;
            epc_q   <= '0;
            cause_q <= '0;
            smode_q <= 1'b0;
        end else if (is_trap) begin
            epc_q   <= trap_pc_i;
            cause_q <= trap_cause_i;
            smode_q <= mode_q;
            mode_q  <= 1'b1;
            mask_q  <= 1'b1;
        end else if (ev_i == EV_RETURN) begin
            mode_q  <= smode_q;
            mask_q  <= 1'b0;
        end
    end

    assign mode_o       = mode_q;
    assign mask_o       = mask_q;
    assign epc_o        = epc_q;
    assign cause_o      = cause_q;
    assign saved_mode_o = smode_q;

    // R10: any trap leaves the block privileged in the next cycle.
    assert_trap_priv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> mode_q);

    // R10: the level moves only at the edge that ends an event cycle.
    assert_mode_only_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(ev_i) != EV_NONE));

    // R8: a return restores the level held before the trap and unmasks.
    assert_return_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RETURN) |=> (mode_q == $past(smode_q)) && !mask_q);

    // R7: the arbiter never accepts an external request while masked.
    assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_IRQ) |-> !mask_q);

endmodule

// File: rtl/precise_trap_ctrl.sv
// Top of the precise trap controller. Commits synchronous faults at
// write-back, takes external requests at the oldest clean instruction,
// squashes the pipeline, saves restart state and redirects fetch.
// Assumes slot NSTG-1 is write-back and that a flush empties every slot.
module precise_trap_ctrl
    import ptc_pkg::*;
#(
    parameter int             NSTG       = 5,
    parameter int             PCW        = 16,
    parameter int             CW         = 4,
    parameter logic [PCW-1:0] HANDLER_PC = 16'h0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSTG-1:0]     slot_valid_i,
    input  logic [NSTG-1:0]     slot_exc_i,
    input  logic [NSTG*PCW-1:0] slot_pc_i,
    input  logic [CW-1:0]       wb_cause_i,
    input  logic                wb_rfi_i,
    input  logic                irq_i,
    output logic                wb_commit_o,
    output logic                flush_o,
    output logic [PCW-1:0]      redirect_pc_o,
    output logic                mode_o,
    output logic [PCW-1:0]      epc_o,
    output logic [CW-1:0]       cause_o,
    output logic                saved_mode_o,
    output logic                irq_masked_o
);

    localparam int            WB       = NSTG - 1;
    localparam logic [CW-1:0] IRQ_CODE = '1;
    localparam logic [CW-1:0] ILL_CODE = IRQ_CODE - 1'b1;

    ptc_event_e     ev;
    logic           pt_found;
    logic           pt_exc;
    logic [PCW-1:0] pt_pc;
    logic [PCW-1:0] wb_pc;
    logic [PCW-1:0] trap_pc;
    logic [CW-1:0]  trap_cause;
    logic           mode;
    logic           mask;
    logic [PCW-1:0] epc;

    assign wb_pc = slot_pc_i[WB*PCW +: PCW];

    ptc_point_pick #(.NSTG(NSTG), .PCW(PCW)) u_pick (
        .slot_valid_i (slot_valid_i),
        .slot_exc_i   (slot_exc_i),
        .slot_pc_i    (slot_pc_i),
        .found_o      (pt_found),
        .found_exc_o  (pt_exc),
        .found_pc_o   (pt_pc)
    );

    ptc_arbiter u_arb (
        .wb_valid_i    (slot_valid_i[WB]),
        .wb_exc_i      (slot_exc_i[WB]),
        .wb_rfi_i      (wb_rfi_i),
        .mode_i        (mode),
        .mask_i        (mask),
        .irq_i         (irq_i),
        .point_found_i (pt_found),
        .point_exc_i   (pt_exc),
        .ev_o          (ev)
    );

    // Select the restart PC and cause code to save for the chosen trap.
    always_comb begin
        trap_pc    = wb_pc;
        trap_cause = wb_cause_i;
        case (ev)
            EV_ILLEGAL: trap_cause = ILL_CODE;
            EV_IRQ: begin
                trap_pc    = pt_pc;
                trap_cause = IRQ_CODE;
            end
            default: ;
        endcase
    end

    ptc_shadow #(.PCW(PCW), .CW(CW)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .trap_pc_i    (trap_pc),
        .trap_cause_i (trap_cause),
        .mode_o       (mode),
        .mask_o       (mask),
        .epc_o        (epc),
        .cause_o      (cause_o),
        .saved_mode_o (saved_mode_o)
    );

    assign flush_o       = (ev != EV_NONE);
    assign redirect_pc_o = (ev == EV_RETURN) ? epc : HANDLER_PC;
    assign wb_commit_o   = slot_valid_i[WB] && ((ev == EV_NONE) || (ev == EV_RETURN));
    assign mode_o        = mode;
    assign epc_o         = epc;
    assign irq_masked_o  = mask;

    // R8: commit and flush together only for a privileged return-from-trap.
    assert_commit_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_commit_o && flush_o) |-> (wb_rfi_i && mode_o));

    // R3: a write-back fault always squashes and blocks its own commit.
    assert_fault_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid_i[WB] && slot_exc_i[WB]) |-> (flush_o && !wb_commit_o));

    // R5: nothing is flushed when the pipeline holds no instruction.
    assert_no_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (slot_valid_i != '0));

    // R3: the trap saves the write-back PC when a fault is taken.
    assert_fault_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid_i[WB] && slot_exc_i[WB]) |=> (epc_o == $past(wb_pc)));

endmodule

// File: tb/precise_trap_ctrl_tb.sv
// Self-checking bench: directed cases then a sweep over all valid and
// exception patterns, checked against a behavioural model of the requirements.
module precise_trap_ctrl_tb;

    localparam int NSTG = 5;
    localparam int PCW  = 16;
    localparam int CW   = 4;
    localparam logic [15:0] HPC = 16'h0100;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NSTG-1:0]     slot_valid_i = '0;
    logic [NSTG-1:0]     slot_exc_i = '0;
    logic [NSTG*PCW-1:0] slot_pc_i = '0;
    logic [CW-1:0]       wb_cause_i = '0;
    logic                wb_rfi_i = 1'b0;
    logic                irq_i = 1'b0;
    logic                wb_commit_o, flush_o, mode_o, saved_mode_o, irq_masked_o;
    logic [PCW-1:0]      redirect_pc_o, epc_o;
    logic [CW-1:0]       cause_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // model state
    logic       m_mode = 1'b1;
    logic       m_mask = 1'b0;
    logic [15:0] m_epc = '0;
    logic [3:0]  m_cause = '0;
    logic       m_smode = 1'b0;

    always #4 clk = ~clk;

    precise_trap_ctrl #(.NSTG(NSTG), .PCW(PCW), .CW(CW), .HANDLER_PC(HPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_valid_i(slot_valid_i), .slot_exc_i(slot_exc_i),
        .slot_pc_i(slot_pc_i), .wb_cause_i(wb_cause_i), .wb_rfi_i(wb_rfi_i), .irq_i(irq_i),
        .wb_commit_o(wb_commit_o), .flush_o(flush_o), .redirect_pc_o(redirect_pc_o),
        .mode_o(mode_o), .epc_o(epc_o), .cause_o(cause_o), .saved_mode_o(saved_mode_o),
        .irq_masked_o(irq_masked_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check combinational outputs,
    // then check saved state after the rising edge.
    task automatic step(input logic [4:0] v, input logic [4:0] e, input logic [3:0] c,
                        input logic irq, input logic rfi, input string tag);
        int ev;
        int pt;
        logic [15:0] base;
        string r;
        @(negedge clk);
        base = 16'h1000 + 16'(cyc * 32);
        cyc++;
        slot_valid_i = v;
        slot_exc_i   = e;
        wb_cause_i   = c;
        irq_i        = irq;
        wb_rfi_i     = rfi;
        for (int s = 0; s < NSTG; s++) slot_pc_i[s*PCW +: PCW] = base + 16'(s * 4);
        pt = -1;
        for (int s = 0; s < NSTG; s++) if (v[s]) pt = s;
        ev = 0;
        if (v[4] && e[4]) ev = 1;
        else if (v[4] && rfi && !m_mode) ev = 2;
        else if (v[4] && rfi) ev = 3;
        else if (irq && !m_mask && pt >= 0 && !e[pt]) ev = 4;
        r = tag;
        if (r == "") begin
            case (ev)
                1: r = irq ? "R6" : "R3";
                2: r = "R9";
                3: r = "R8";
                4: r = "R4";
                default: r = (irq && m_mask) ? "R7" : (irq ? "R5" : "R2");
            endcase
        end
        #1;
        chk(r, "commit", 32'(wb_commit_o), 32'(v[4] && (ev == 0 || ev == 3)));
        chk(r, "flush", 32'(flush_o), 32'(ev != 0));
        if (ev != 0) chk(r, "redirect_pc", 32'(redirect_pc_o), 32'((ev == 3) ? m_epc : HPC));
        chk("R10", "mode_in_cycle", 32'(mode_o), 32'(m_mode));
        @(posedge clk);
        #1;
        if (ev == 1 || ev == 2 || ev == 4) begin
            m_epc   = (ev == 4) ? base + 16'(pt * 4) : base + 16'd16;
            m_cause = (ev == 1) ? c : ((ev == 2) ? 4'd14 : 4'd15);
            m_smode = m_mode;
            m_mode  = 1'b1;
            m_mask  = 1'b1;
        end else if (ev == 3) begin
            m_mode = m_smode;
            m_mask = 1'b0;
        end
        chk((ev == 0) ? r : "R10", "mode", 32'(mode_o), 32'(m_mode));
        chk(r, "mask", 32'(irq_masked_o), 32'(m_mask));
        chk(r, "epc", 32'(epc_o), 32'(m_epc));
        chk(r, "cause", 32'(cause_o), 32'(m_cause));
        chk(r, "saved_mode", 32'(saved_mode_o), 32'(m_smode));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "mode", 32'(mode_o), 32'd1);
        chk("R1", "mask", 32'(irq_masked_o), 32'd0);
        chk("R1", "epc", 32'(epc_o), 32'd0);
        chk("R1", "cause", 32'(cause_o), 32'd0);
        chk("R1", "saved_mode", 32'(saved_mode_o), 32'd0);
        chk("R1", "flush", 32'(flush_o), 32'd0);

        step(5'b00100, 5'b00100, 4'd2, 1'b0, 1'b0, "R11"); // fault not yet at write-back
        step(5'b00000, 5'b00000, 4'd0, 1'b1, 1'b0, "R5");  // empty pipeline defers request
        step(5'b00110, 5'b00100, 4'd0, 1'b1, 1'b0, "R5");  // oldest instruction faulting
        step(5'b10000, 5'b00000, 4'd0, 1'b0, 1'b1, "R8");  // return to user mode
        step(5'b11111, 5'b10000, 4'd3, 1'b1, 1'b0, "R6");  // fault beats request
        step(5'b11111, 5'b00000, 4'd0, 1'b1, 1'b0, "R7");  // masked request ignored
        step(5'b10000, 5'b00000, 4'd0, 1'b0, 1'b1, "R8");  // return, unmask
        step(5'b01011, 5'b00000, 4'd0, 1'b1, 1'b0, "R4");  // request at slot 3
        step(5'b10000, 5'b00000, 4'd0, 1'b0, 1'b1, "R8");  // back to user mode
        step(5'b10000, 5'b00000, 4'd0, 1'b0, 1'b1, "R9");  // user return is illegal
        step(5'b10101, 5'b00000, 4'd0, 1'b0, 1'b0, "R2");  // plain commit

        // Sweep every valid and exception pattern with each request/return setting.
        for (int v = 0; v < 32; v++) begin
            for (int e = 0; e < 32; e++) begin
                for (int k = 0; k < 4; k++) begin
                    step(5'(v), 5'(e), 4'(v ^ e), k[0], k[1], "");
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule